// File: doc/BRIEF.md
# Two-Stage Sticky Interrupt Collector

This block gathers seventeen level-sensitive serial interrupt lines and nine single-cycle error events into one interrupt output. The signals pass through two register stages in a row. The first stage holds a sticky status word, a mask and a control word with a global enable. Its masked, enabled OR appears as bit 11 of a read-only input word in the second stage. The second stage ANDs that input word with its own mask and accumulates the result into a second sticky status word. The interrupt output is high whenever that second status word is nonzero.

Software talks to the block through a flat 32-bit register port. A write takes effect at the clock edge on which it is presented. Read data is a combinational function of the address. Both status words are cleared by writing ones. The second stage also has a polarity word, which can be read and written but has no effect on the interrupt path. Two further words, a segment word and a read-size word, are plain storage.

Top module: `irq_cascade_top`

## Requirements
- R1: After reset, every register reads zero except the read-size word at offset 0x28, which reads 0x02000000, and irq_o is low.
- R2: A high level on serial line n (0..16) sets status bit 31-n of the first-stage status at offset 0x38 on the next clock edge. A low level never clears that bit.
- R3: Error pulse input k sets first-stage status bit k for k in 0..7. Pulse input 8, the reset event, sets bit 10.
- R4: A write to offset 0x38 clears every status bit written as one and leaves the other bits alone. If a set and a clear hit the same bit in one cycle, the bit stays set.
- R5: A write to offset 0x24, 0x28, 0x30 (control), 0x34 (first-stage mask), 0x54 (second-stage mask) or 0x58 (polarity) replaces the whole word, and the new value reads back.
- R6: Bit 11 of the input word at offset 0x5C is high exactly when control bit 31 is set and the first-stage status ANDed with its mask is nonzero. This word reflects a change in those registers without a clock delay. No other bit of the input word is ever set.
- R7: Writes to the error-address word at offset 0x40 and to the input word at offset 0x5C are ignored. The error-address word always reads zero.
- R8: On each clock edge the second-stage status at offset 0x50 ORs in the input word ANDed with the second-stage mask, taking both values from before the edge. Its bits are sticky, and a write of ones clears them. If a set and a clear hit the same bit in one cycle, the bit stays set.
- R9: irq_o is high exactly when the second-stage status is nonzero, whatever the polarity word holds.
- R10: A read of any offset not listed above returns 0xFFFFFFFF, and a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| ser_i | input | 17 | Serial interrupt levels, line n at bit n |
| err_i | input | 9 | Error event pulses; bit 8 is the reset event |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
A wrong first-stage status bit shows up at offset 0x38 right after the clock edge that sets or clears it. It also reaches bit 11 of offset 0x5C without further delay, provided the enable and mask let it through. A fault in the second stage or in the link between the stages shows at offset 0x50 and on irq_o exactly one edge later. Sticky bits that fail to hold are caught by reads taken after their source has fallen. Clears that defeat a simultaneous set are caught by writing a clear while the source is still held high.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int DW       = 32;
  localparam int AW       = 8;
  localparam int EN_BIT   = 31;
  localparam int LINK_BIT = 11;
  localparam int RST_EV_BIT = 10;

  localparam logic [AW-1:0] OFS_SEG     = 8'h24;
  localparam logic [AW-1:0] OFS_RDSZ    = 8'h28;
  localparam logic [AW-1:0] OFS_S1_CTRL = 8'h30;
  localparam logic [AW-1:0] OFS_S1_MASK = 8'h34;
  localparam logic [AW-1:0] OFS_S1_STAT = 8'h38;
  localparam logic [AW-1:0] OFS_ERRADR  = 8'h40;
  localparam logic [AW-1:0] OFS_S2_STAT = 8'h50;
  localparam logic [AW-1:0] OFS_S2_MASK = 8'h54;
  localparam logic [AW-1:0] OFS_S2_POL  = 8'h58;
  localparam logic [AW-1:0] OFS_S2_IN   = 8'h5C;

  localparam logic [DW-1:0] RDSZ_RST = 32'h0200_0000;

  // error pulse index -> status bit; the last pulse is the reset event
  function automatic int err_pos(input int idx, input int num_err);
    return (idx == num_err - 1) ? RST_EV_BIT : idx;
  endfunction
endpackage

// File: rtl/irq_cascade_s1.sv
module irq_cascade_s1
  import irq_cascade_pkg::*;
#(
  parameter int NUM_SER = 17,
  parameter int NUM_ERR = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [NUM_SER-1:0] ser_i,
  input  logic [NUM_ERR-1:0] err_i,
  output logic [DW-1:0]      seg_o,
  output logic [DW-1:0]      rdsz_o,
  output logic [DW-1:0]      ctrl_o,
  output logic [DW-1:0]      mask_o,
  output logic [DW-1:0]      stat_o,
  output logic               link_o
);
  logic [DW-1:0] seg_q, rdsz_q, ctrl_q, mask_q, stat_q;
  logic [DW-1:0] set_vec, clr_vec;

  always_comb begin
    set_vec = '0;
    for (int n = 0; n < NUM_SER; n++) set_vec[DW-1-n] = set_vec[DW-1-n] | ser_i[n];
    for (int k = 0; k < NUM_ERR; k++)
      set_vec[err_pos(k, NUM_ERR)] = set_vec[err_pos(k, NUM_ERR)] | err_i[k];
  end

  assign clr_vec = (wr_en_i && addr_i == OFS_S1_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= '0;
      rdsz_q <= RDSZ_RST;
      ctrl_q <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_vec) | set_vec;  // set wins
      if (wr_en_i) begin
        case (addr_i)
          OFS_SEG:     seg_q  <= wdata_i;
          OFS_RDSZ:    rdsz_q <= wdata_i;
          OFS_S1_CTRL: ctrl_q <= wdata_i;
          OFS_S1_MASK: mask_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign link_o = ctrl_q[EN_BIT] & (|(stat_q & mask_q));
  assign seg_o  = seg_q;
  assign rdsz_o = rdsz_q;
  assign ctrl_o = ctrl_q;
  assign mask_o = mask_q;
  assign stat_o = stat_q;

  // bits survive unless a clear was written
  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(stat_q) & ~$past(clr_vec)) & ~stat_q) == '0));
  // every raised source is visible one edge later
  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_vec) & ~stat_q) == '0));
  p_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[EN_BIT] |-> !link_o);
endmodule

// File: rtl/irq_cascade_s2.sv
module irq_cascade_s2
  import irq_cascade_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          link_i,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] pol_o,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] in_o,
  output logic          irq_o
);
  logic [DW-1:0] mask_q, pol_q, stat_q, in_vec, clr_vec;

  always_comb begin
    in_vec = '0;
    in_vec[LINK_BIT] = link_i;
  end

  assign clr_vec = (wr_en_i && addr_i == OFS_S2_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      pol_q  <= '0;
      stat_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_vec) | (in_vec & mask_q);
      if (wr_en_i) begin
        case (addr_i)
          OFS_S2_MASK: mask_q <= wdata_i;
          OFS_S2_POL:  pol_q  <= wdata_i;  // stored only
          default: ;
        endcase
      end
    end
  end

  assign irq_o  = |stat_q;
  assign mask_o = mask_q;
  assign pol_o  = pol_q;
  assign stat_o = stat_q;
  assign in_o   = in_vec;

  p_latch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_i && mask_q[LINK_BIT]) |=> stat_q[LINK_BIT]);
  p_irq_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(wr_en_i && addr_i == OFS_S2_STAT)) |=> irq_o);
endmodule

// File: rtl/irq_cascade_top.sv
module irq_cascade_top
  import irq_cascade_pkg::*;
#(
  parameter int NUM_SER = 17,
  parameter int NUM_ERR = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic [NUM_SER-1:0] ser_i,
  input  logic [NUM_ERR-1:0] err_i,
  output logic               irq_o
);
  logic [DW-1:0] seg, rdsz, ctrl, mask1, stat1;
  logic [DW-1:0] mask2, pol2, stat2, in2;
  logic          link;

  irq_cascade_s1 #(.NUM_SER(NUM_SER), .NUM_ERR(NUM_ERR)) u_s1 (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .ser_i, .err_i,
    .seg_o(seg), .rdsz_o(rdsz), .ctrl_o(ctrl), .mask_o(mask1),
    .stat_o(stat1), .link_o(link)
  );

  irq_cascade_s2 u_s2 (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .link_i(link),
    .mask_o(mask2), .pol_o(pol2), .stat_o(stat2), .in_o(in2), .irq_o
  );

  always_comb begin
    case (addr_i)
      OFS_SEG:     rdata_o = seg;
      OFS_RDSZ:    rdata_o = rdsz;
      OFS_S1_CTRL: rdata_o = ctrl;
      OFS_S1_MASK: rdata_o = mask1;
      OFS_S1_STAT: rdata_o = stat1;
      OFS_ERRADR:  rdata_o = '0;
      OFS_S2_STAT: rdata_o = stat2;
      OFS_S2_MASK: rdata_o = mask2;
      OFS_S2_POL:  rdata_o = pol2;
      OFS_S2_IN:   rdata_o = in2;
      default:     rdata_o = '1;
    endcase
  end

  // second stage can only rise from the link bit
  p_rise_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(link));
endmodule

// File: tb/sim_irq_cascade_top.sv
`timescale 1ns/1ps
module sim_irq_cascade_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [16:0] ser = '0;
  logic [8:0]  err = '0;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_cascade_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ser_i(ser), .err_i(err), .irq_o(irq)
  );

  // {offset, write value, expected readback}
  localparam logic [71:0] VEC [12] = '{
    {8'h5C, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h40, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h24, 32'hA5A5_0001, 32'hA5A5_0001},
    {8'h28, 32'h0100_0000, 32'h0100_0000},
    {8'h34, 32'h0000_FFFF, 32'h0000_FFFF},
    {8'h30, 32'h4000_0000, 32'h4000_0000},
    {8'h58, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {8'h54, 32'h0000_0800, 32'h0000_0800},
    {8'h00, 32'h0000_0001, 32'hFFFF_FFFF},
    {8'h2C, 32'h0000_0000, 32'hFFFF_FFFF},
    {8'h60, 32'h1234_5678, 32'hFFFF_FFFF},
    {8'h3C, 32'h0000_0000, 32'hFFFF_FFFF}
  };
  string vec_tag [12] = '{"R7", "R7", "R5", "R5", "R5", "R5",
                          "R5", "R5", "R10", "R10", "R10", "R10"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    addr = a; #0.5;
    check(tag, rdata, exp);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    tick();
    // R1 reset state
    rd("R1", 8'h28, 32'h0200_0000);
    rd("R1", 8'h30, 32'h0);
    rd("R1", 8'h38, 32'h0);
    rd("R1", 8'h50, 32'h0);
    check("R1", {31'b0, irq}, 32'h0);

    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(vec_tag[i], VEC[i][71:64], VEC[i][31:0]);
    end
    wr(8'h34, 0); wr(8'h54, 0); wr(8'h30, 0); wr(8'h58, 0);

    // R2 serial lines, bit-reversed, sticky
    ser[0] = 1'b1; tick(); ser[0] = 1'b0; tick();
    rd("R2", 8'h38, 32'h8000_0000);
    ser[16] = 1'b1; tick(); ser[16] = 1'b0; tick();
    rd("R2", 8'h38, 32'h8000_8000);

    // R3 error pulses
    err[8] = 1'b1; err[0] = 1'b1; tick(); err = '0;
    rd("R3", 8'h38, 32'h8000_8401);

    // R4 write-one-to-clear and set-wins
    wr(8'h38, 32'h8000_0001);
    rd("R4", 8'h38, 32'h0000_8400);
    ser[16] = 1'b1;
    wr(8'h38, 32'h0000_8000);
    rd("R4", 8'h38, 32'h0000_8400);
    ser[16] = 1'b0;
    wr(8'h38, 32'h0000_8000);
    rd("R4", 8'h38, 32'h0000_0400);
    wr(8'h38, 32'hFFFF_FFFF);
    rd("R4", 8'h38, 32'h0);

    // R6 enable gate and link bit
    ser[5] = 1'b1; tick(); ser[5] = 1'b0;
    wr(8'h34, 32'h0400_0000);
    rd("R6", 8'h5C, 32'h0);
    wr(8'h30, 32'h8000_0000);
    rd("R6", 8'h5C, 32'h0000_0800);

    // R8 second-stage mask, one-edge latency
    tick();
    rd("R8", 8'h50, 32'h0);
    check("R9", {31'b0, irq}, 32'h0);
    wr(8'h54, 32'h0000_0800);
    rd("R8", 8'h50, 32'h0);
    tick();
    rd("R8", 8'h50, 32'h0000_0800);
    check("R9", {31'b0, irq}, 32'h1);

    // R9 polarity has no effect
    wr(8'h58, 32'hFFFF_FFFF);
    rd("R9", 8'h58, 32'hFFFF_FFFF);
    tick();
    check("R9", {31'b0, irq}, 32'h1);
    wr(8'h58, 32'h0);
    tick();
    check("R9", {31'b0, irq}, 32'h1);

    // R8 set-wins, sticky, clear
    wr(8'h50, 32'h0000_0800);
    rd("R8", 8'h50, 32'h0000_0800);
    wr(8'h38, 32'h0400_0000);
    rd("R6", 8'h5C, 32'h0);
    tick();
    rd("R8", 8'h50, 32'h0000_0800);
    wr(8'h50, 32'h0000_0800);
    rd("R8", 8'h50, 32'h0);
    check("R9", {31'b0, irq}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule